// File: doc/BRIEF.md
# Flash partition table locator

This block finds a named partition inside a memory-mapped flash window. When it receives a start pulse, it probes the window from the top downward, one 4 KiB boundary at a time, for a partition-table header. A header is accepted only if its magic word and version word are correct and all of its words XOR to zero. The accepted header gives the flash base, the table's entry count and the block size. The block then walks the table entries in order. It stops at the first entry whose leading name word equals the requested 4-character name and whose words also XOR to zero.

From the matching entry and its two user-flag words, the block computes three results. These are the partition's byte offset within the window, its usable size, and a flag that shows whether the partition carries ECC. The offset includes any header skips that the flags call for. All flash traffic goes through a simple 32-bit read master, with one request outstanding at a time. A one-cycle pulse reports the outcome as either found or missing.

Top module: `pt_locator`

## Requirements
- R1: A start pulse while idle begins a scan. Candidate header offsets are WIN_BYTES-STEP first, then each one STEP lower, down to and including offset 0. The first read of a scan is at WIN_BYTES-STEP.
- R2: A candidate is abandoned if its magic word (word 0, default 32'h5041_5254) differs or its version word (word 1) is not 1. The scan then moves to the next lower candidate.
- R3: A candidate is accepted only if the XOR of all HDR_WORDS (12) header words, including its checksum word, is zero. The entry count is word 4, the block size word 5 and the block count word 6.
- R4: If candidate offset 0 is rejected, or an accepted table has no matching entry, done_missing pulses and part_base, part_size and part_ecc read zero.
- R5: Entry i starts at header + HDR_WORDS*4 + i*ENT_WORDS*4 (ENT_WORDS = 8), and entries are tried in ascending order. An entry matches only if word 0 equals the name sampled at start and all ENT_WORDS words XOR to zero. The first match ends the search with a done_found pulse.
- R6: part_base = WIN_BYTES - block_size*block_count + block_size*entry word 1. Without ECC, part_size = entry word 3.
- R7: If bit 15 of entry word 4 is set, part_ecc is 1 and part_size = floor(word3/9)*8. Otherwise part_ecc is 0 and the other bits of the word have no effect.
- R8: If bit 31 of entry word 5 is set, part_base advances by 0x1000, and by a further 0x200 when R7's ECC bit is set. Other bits of word 5 have no effect.
- R9: rd_req stays high with rd_addr stable until rd_ack. rd_data is taken in the rd_ack cycle. Every rd_addr is a multiple of 4.
- R10: A start pulse while busy is ignored, and changes on target_name after start do not affect the running search.
- R11: After reset, busy, rd_req, done_found and done_missing are low and all results are zero.
- R12: Each done pulse lasts one cycle, and busy falls in that same cycle. The results then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (ignored while busy) |
| target_name | input | 32 | Four-character name sought, sampled at start |
| rd_req | output | 1 | Read request to the window |
| rd_addr | output | ADDR_W | Byte offset of the requested word |
| rd_ack | input | 1 | Read response strobe |
| rd_data | input | 32 | Read response word |
| busy | output | 1 | Search in progress |
| done_found | output | 1 | One-cycle pulse: partition found |
| done_missing | output | 1 | One-cycle pulse: no header or no matching entry |
| part_base | output | 32 | Partition byte offset within the window |
| part_size | output | 32 | Usable partition size in bytes |
| part_ecc | output | 1 | Partition carries ECC |

## Verification
The table is placed at the top candidate, at a middle candidate and at offset 0. These placements separate a correct downward step sequence and end condition from off-by-one scanning. The flag words are driven with ECC only, with header skip only, with both, and with every other bit set. This separates the size scaling and the two skip amounts from each other and from decoding on the wrong bit. The failure patterns are a broken header checksum, a wrong version, a broken target-entry checksum and an absent name. Each of these must give done_missing, so it shows which validation step guards the result. A second start during a search, with a changed name, checks that the running search keeps the name it sampled at start.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HREQ,
        ST_HWAIT,
        ST_HEVAL,
        ST_EREQ,
        ST_EWAIT,
        ST_EEVAL
    } loc_state_e;

    // Fields kept from an accepted header
    typedef struct packed {
        logic [31:0] ecount;
        logic [31:0] bsize;
        logic [31:0] bcount;
    } tbl_hdr_t;

    // Fields kept from the entry being examined
    typedef struct packed {
        logic [31:0] name;
        logic [31:0] ebase;
        logic [31:0] actual;
        logic        ecc;
        logic        skip;
    } tbl_ent_t;

    // Result handed to the ports
    typedef struct packed {
        logic [31:0] base;
        logic [31:0] size;
        logic        ecc;
    } part_info_t;

    localparam logic [31:0] VERSION_ONE = 32'd1;

    // Payload bytes left once one check byte per 8 data bytes is removed
    function automatic logic [31:0] ecc_payload(input logic [31:0] raw);
        logic [31:0] groups;
        groups = raw / 32'd9;
        return groups << 3;
    endfunction

endpackage

// File: rtl/pt_word_fetch.sv
module pt_word_fetch #(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    output logic              vld,
    output logic [31:0]       data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_req  <= 1'b0;
            rd_addr <= '0;
            vld     <= 1'b0;
            data    <= '0;
        end else begin
            vld <= 1'b0;
            if (go) begin
                rd_req  <= 1'b1;
                rd_addr <= {addr[ADDR_W-1:2], 2'b00};
            end else if (rd_req && rd_ack) begin
                rd_req <= 1'b0;
                vld    <= 1'b1;
                data   <= rd_data;
            end
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R9
    go_idle_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> !rd_req);

    // R9
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[1:0] == 2'b00));

endmodule

// File: rtl/pt_xor_acc.sv
module pt_xor_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic         zero
);

    logic [W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (en)    acc <= acc ^ din;
    end

    assign zero = (acc == '0);

endmodule

// File: rtl/pt_result_calc.sv
module pt_result_calc
    import pt_pkg::*;
#(
    parameter logic [31:0] WIN_BYTES    = 32'h1000_0000,
    parameter logic [31:0] HDR_SKIP     = 32'h0000_1000,
    parameter logic [31:0] ECC_HDR_SKIP = 32'h0000_0200
) (
    input  tbl_hdr_t   hdr,
    input  tbl_ent_t   ent,
    output part_info_t info
);

    logic [31:0] flash_base;
    logic [31:0] skip_bytes;

    always_comb begin
        flash_base = WIN_BYTES - hdr.bsize * hdr.bcount;
        skip_bytes = '0;
        if (ent.skip) begin
            skip_bytes = HDR_SKIP;
            if (ent.ecc) skip_bytes = HDR_SKIP + ECC_HDR_SKIP;
        end
        info.base = flash_base + hdr.bsize * ent.ebase + skip_bytes;
        info.size = ent.ecc ? ecc_payload(ent.actual) : ent.actual;
        info.ecc  = ent.ecc;
    end

endmodule

// File: rtl/pt_locator.sv
module pt_locator
    import pt_pkg::*;
#(
    parameter logic [31:0] WIN_BYTES    = 32'h1000_0000,
    parameter logic [31:0] STEP         = 32'h0000_1000,
    parameter logic [31:0] MAGIC        = 32'h5041_5254,
    parameter int          HDR_WORDS    = 12,
    parameter int          HF_MAGIC     = 0,
    parameter int          HF_VER       = 1,
    parameter int          HF_ECOUNT    = 4,
    parameter int          HF_BSIZE     = 5,
    parameter int          HF_BCOUNT    = 6,
    parameter int          ENT_WORDS    = 8,
    parameter int          EF_NAME      = 0,
    parameter int          EF_BASE      = 1,
    parameter int          EF_ACTUAL    = 3,
    parameter int          EF_USER0     = 4,
    parameter int          EF_USER1     = 5,
    parameter int          ECC_BIT      = 15,
    parameter int          SKIP_BIT     = 31,
    parameter logic [31:0] HDR_SKIP     = 32'h0000_1000,
    parameter logic [31:0] ECC_HDR_SKIP = 32'h0000_0200,
    parameter int          ADDR_W       = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       target_name,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              done_found,
    output logic              done_missing,
    output logic [31:0]       part_base,
    output logic [31:0]       part_size,
    output logic              part_ecc
);

    localparam int MAXW   = (HDR_WORDS > ENT_WORDS) ? HDR_WORDS : ENT_WORDS;
    localparam int WIDX_W = $clog2(MAXW + 1);
    localparam logic [31:0]       HDR_BYTES = 32'(HDR_WORDS * 4);
    localparam logic [31:0]       ENT_BYTES = 32'(ENT_WORDS * 4);
    localparam logic [ADDR_W-1:0] TOP_CAND  = ADDR_W'(WIN_BYTES - STEP);
    localparam logic [ADDR_W-1:0] STEP_A    = ADDR_W'(STEP);

    loc_state_e        state;
    logic [ADDR_W-1:0] cand_addr;
    logic [WIDX_W-1:0] widx;
    logic [31:0]       ent_idx;
    logic [31:0]       name_q;
    tbl_hdr_t          hdr_q;
    tbl_ent_t          ent_q;
    part_info_t        res_q;
    part_info_t        calc;

    logic              f_go;
    logic [ADDR_W-1:0] f_addr;
    logic              f_vld;
    logic [31:0]       f_data;
    logic              acc_zero;
    logic [31:0]       ent_off;
    logic              hdr_bad_word;
    logic              last_cand;
    logic              last_hword;
    logic              last_eword;
    logic              last_entry;

    // Request issue and address generation
    always_comb begin
        f_go    = (state == ST_HREQ) || (state == ST_EREQ);
        ent_off = HDR_BYTES + ent_idx * ENT_BYTES + (32'(widx) << 2);
        if (state == ST_EREQ) f_addr = cand_addr + ent_off[ADDR_W-1:0];
        else                  f_addr = cand_addr + ADDR_W'(32'(widx) << 2);
    end

    always_comb begin
        hdr_bad_word = ((widx == WIDX_W'(HF_MAGIC)) && (f_data != MAGIC)) ||
                       ((widx == WIDX_W'(HF_VER))   && (f_data != VERSION_ONE));
        last_cand  = (cand_addr == '0);
        last_hword = (widx == WIDX_W'(HDR_WORDS - 1));
        last_eword = (widx == WIDX_W'(ENT_WORDS - 1));
        last_entry = ((ent_idx + 32'd1) == hdr_q.ecount);
    end

    pt_word_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .go     (f_go),
        .addr   (f_addr),
        .rd_req (rd_req),
        .rd_addr(rd_addr),
        .rd_ack (rd_ack),
        .rd_data(rd_data),
        .vld    (f_vld),
        .data   (f_data)
    );

    pt_xor_acc #(.W(32)) u_xor (
        .clk (clk),
        .rst (rst),
        .clr (f_go && (widx == '0)),
        .en  (f_vld),
        .din (f_data),
        .zero(acc_zero)
    );

    pt_result_calc #(
        .WIN_BYTES   (WIN_BYTES),
        .HDR_SKIP    (HDR_SKIP),
        .ECC_HDR_SKIP(ECC_HDR_SKIP)
    ) u_calc (
        .hdr (hdr_q),
        .ent (ent_q),
        .info(calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            busy         <= 1'b0;
            done_found   <= 1'b0;
            done_missing <= 1'b0;
            cand_addr    <= '0;
            widx         <= '0;
            ent_idx      <= '0;
            name_q       <= '0;
            hdr_q        <= '0;
            ent_q        <= '0;
            res_q        <= '0;
        end else begin
            done_found   <= 1'b0;
            done_missing <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        busy      <= 1'b1;
                        name_q    <= target_name;
                        res_q     <= '0;
                        cand_addr <= TOP_CAND;
                        widx      <= '0;
                        state     <= ST_HREQ;
                    end
                end
                ST_HREQ: state <= ST_HWAIT;
                ST_HWAIT: begin
                    if (f_vld) begin
                        if (widx == WIDX_W'(HF_ECOUNT)) hdr_q.ecount <= f_data;
                        if (widx == WIDX_W'(HF_BSIZE))  hdr_q.bsize  <= f_data;
                        if (widx == WIDX_W'(HF_BCOUNT)) hdr_q.bcount <= f_data;
                        if (hdr_bad_word) begin
                            widx <= '0;
                            if (last_cand) begin
                                busy         <= 1'b0;
                                done_missing <= 1'b1;
                                state        <= ST_IDLE;
                            end else begin
                                cand_addr <= cand_addr - STEP_A;
                                state     <= ST_HREQ;
                            end
                        end else if (last_hword) begin
                            state <= ST_HEVAL;
                        end else begin
                            widx  <= widx + 1'b1;
                            state <= ST_HREQ;
                        end
                    end
                end
                ST_HEVAL: begin
                    widx <= '0;
                    if (!acc_zero) begin
                        if (last_cand) begin
                            busy         <= 1'b0;
                            done_missing <= 1'b1;
                            state        <= ST_IDLE;
                        end else begin
                            cand_addr <= cand_addr - STEP_A;
                            state     <= ST_HREQ;
                        end
                    end else if (hdr_q.ecount == '0) begin
                        busy         <= 1'b0;
                        done_missing <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        ent_idx <= '0;
                        state   <= ST_EREQ;
                    end
                end
                ST_EREQ: state <= ST_EWAIT;
                ST_EWAIT: begin
                    if (f_vld) begin
                        if (widx == WIDX_W'(EF_NAME))   ent_q.name   <= f_data;
                        if (widx == WIDX_W'(EF_BASE))   ent_q.ebase  <= f_data;
                        if (widx == WIDX_W'(EF_ACTUAL)) ent_q.actual <= f_data;
                        if (widx == WIDX_W'(EF_USER0))  ent_q.ecc    <= f_data[ECC_BIT];
                        if (widx == WIDX_W'(EF_USER1))  ent_q.skip   <= f_data[SKIP_BIT];
                        if (last_eword) begin
                            state <= ST_EEVAL;
                        end else begin
                            widx  <= widx + 1'b1;
                            state <= ST_EREQ;
                        end
                    end
                end
                ST_EEVAL: begin
                    widx <= '0;
                    if (acc_zero && (ent_q.name == name_q)) begin
                        res_q      <= calc;
                        busy       <= 1'b0;
                        done_found <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (last_entry) begin
                        busy         <= 1'b0;
                        done_missing <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        ent_idx <= ent_idx + 32'd1;
                        state   <= ST_EREQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign part_base = res_q.base;
    assign part_size = res_q.size;
    assign part_ecc  = res_q.ecc;

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_found && done_missing));

    // R12
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done_found || done_missing));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(part_base) && $stable(part_size) && $stable(part_ecc)));

    // R4
    missing_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done_missing |-> (part_base == '0 && part_size == '0 && !part_ecc));

    // R7
    ecc_size_chk: assert property (@(posedge clk) disable iff (rst)
        (done_found && part_ecc) |-> (part_size[2:0] == 3'b000));

    // R10
    name_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(name_q));

endmodule

// File: tb/pt_locator_tb.sv
module pt_locator_tb_top;

    localparam logic [31:0] WIN    = 32'h0000_8000;
    localparam int          AW     = $clog2(WIN);
    localparam logic [31:0] MAGIC  = 32'h5041_5254;
    localparam logic [31:0] BS     = 32'h0000_0100;
    localparam logic [31:0] BC     = 32'h0000_0040;
    localparam logic [31:0] TARGET = 32'h424F_4F54;
    localparam logic [31:0] DECOY  = 32'h4443_4F59;

    // mode: 0 good, 1 bad header checksum, 2 bad version,
    //       3 bad target entry checksum, 4 target name absent
    typedef struct packed {
        logic [31:0] hdr_off;
        logic [3:0]  mode;
        logic [31:0] ebase;
        logic [31:0] actual;
        logic [31:0] u0;
        logic [31:0] u1;
        logic        exp_found;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h7000, 4'd0, 32'd2, 32'h900,  32'h0,    32'h0,         1'b1},
        '{32'h3000, 4'd0, 32'd5, 32'h1200, 32'h8000, 32'h0,         1'b1},
        '{32'h0000, 4'd0, 32'd1, 32'd100,  32'h8000, 32'h8000_0000, 1'b1},
        '{32'h5000, 4'd0, 32'd3, 32'd77,   32'h0,    32'h8000_0000, 1'b1},
        '{32'h7000, 4'd1, 32'd2, 32'h900,  32'h0,    32'h0,         1'b0},
        '{32'h7000, 4'd2, 32'd2, 32'h900,  32'h0,    32'h0,         1'b0},
        '{32'h7000, 4'd3, 32'd2, 32'h900,  32'h0,    32'h0,         1'b0},
        '{32'h6000, 4'd4, 32'd2, 32'h900,  32'h0,    32'h0,         1'b0},
        '{32'h2000, 4'd0, 32'd0, 32'd9,    32'h7FFF, 32'h7F00_0000, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [31:0]   target_name;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack;
    logic [31:0]   rd_data;
    logic          busy, done_found, done_missing, part_ecc;
    logic [31:0]   part_base, part_size;

    logic [31:0] mem [int];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pt_locator #(.WIN_BYTES(WIN), .MAGIC(MAGIC)) dut_i (
        .clk(clk), .rst(rst), .start(start), .target_name(target_name),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done_found(done_found), .done_missing(done_missing),
        .part_base(part_base), .part_size(part_size), .part_ecc(part_ecc)
    );

    // Flash window responder: one-cycle latency
    initial begin
        rd_ack  = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            if (rd_req && !rd_ack) begin
                rd_ack  = 1'b1;
                rd_data = mem.exists(int'(rd_addr)) ? mem[int'(rd_addr)] : 32'h0;
            end else begin
                rd_ack = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mdl_base(input vec_t v);
        logic [31:0] b;
        b = WIN - BS * BC + BS * v.ebase;
        if (v.u1[31]) b = b + 32'h1000 + (v.u0[15] ? 32'h200 : 32'h0);
        return b;
    endfunction

    function automatic logic [31:0] mdl_size(input vec_t v);
        return v.u0[15] ? (v.actual / 32'd9) * 32'd8 : v.actual;
    endfunction

    task automatic build(input vec_t v);
        logic [31:0] h [12];
        logic [31:0] e [8];
        logic [31:0] x;
        mem.delete();
        h[0] = MAGIC;
        h[1] = (v.mode == 4'd2) ? 32'd2 : 32'd1;
        h[2] = 32'h1000; h[3] = 32'd32; h[4] = 32'd2;
        h[5] = BS; h[6] = BC;
        h[7] = 32'h1111; h[8] = 32'h2222; h[9] = 32'h3333; h[10] = 32'h4444;
        x = '0;
        for (int k = 0; k < 11; k++) x ^= h[k];
        h[11] = (v.mode == 4'd1) ? (x ^ 32'h1) : x;
        for (int k = 0; k < 12; k++) mem[int'(v.hdr_off) + 4*k] = h[k];
        for (int n = 0; n < 2; n++) begin
            if (n == 0) begin
                e[0] = DECOY; e[1] = 32'd9; e[3] = 32'd5; e[4] = '0; e[5] = '0;
            end else begin
                e[0] = (v.mode == 4'd4) ? 32'h5A5A_5A5A : TARGET;
                e[1] = v.ebase; e[3] = v.actual; e[4] = v.u0; e[5] = v.u1;
            end
            e[2] = 32'h1234; e[6] = 32'h0;
            x = '0;
            for (int k = 0; k < 7; k++) x ^= e[k];
            e[7] = (n == 1 && v.mode == 4'd3) ? (x ^ 32'h80) : x;
            for (int k = 0; k < 8; k++) mem[int'(v.hdr_off) + 48 + 32*n + 4*k] = e[k];
        end
    endtask

    task automatic pulse_start(input logic [31:0] nm);
        @(negedge clk);
        target_name = nm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output logic f, output logic m);
        f = 1'b0; m = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done_found || done_missing) begin
                f = done_found; m = done_missing;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R12: actual hung, expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic f, m;
        logic [31:0] b0;
        start = 1'b0;
        target_name = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 busy", {31'b0, busy}, 32'h0);
        chk("R11 rd_req", {31'b0, rd_req}, 32'h0);
        chk("R11 done", {30'b0, done_found, done_missing}, 32'h0);
        chk("R11 base", part_base, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1: first read at the top candidate
        build(VECS[0]);
        pulse_start(TARGET);
        for (int k = 0; k < 20 && !rd_req; k++) @(negedge clk);
        chk("R1 first addr", 32'(rd_addr), WIN - 32'h1000);
        chk("R9 aligned", {30'b0, rd_addr[1:0]}, 32'h0);
        wait_done(f, m);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            build(VECS[i]);
            pulse_start(TARGET);
            wait_done(f, m);
            chk("R5 found", {31'b0, f}, {31'b0, VECS[i].exp_found});
            if (VECS[i].exp_found) begin
                chk("R6/R8 base", part_base, mdl_base(VECS[i]));
                chk("R6/R7 size", part_size, mdl_size(VECS[i]));
                chk("R7 ecc", {31'b0, part_ecc}, {31'b0, VECS[i].u0[15]});
            end else begin
                // R2 R3 R4: rejected header or entry ends in missing with zero results
                chk("R4 missing", {31'b0, m}, 32'h1);
                chk("R4 zero", part_base | part_size, 32'h0);
            end
        end

        // R10: second start with another name during the search is ignored
        build(VECS[0]);
        pulse_start(TARGET);
        repeat (8) @(negedge clk);
        target_name = DECOY;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(f, m);
        chk("R10 found", {31'b0, f}, 32'h1);
        chk("R10 base", part_base, mdl_base(VECS[0]));
        b0 = part_base;

        // R12: pulse lasts one cycle, results held
        @(negedge clk);
        chk("R12 pulse", {30'b0, done_found, done_missing}, 32'h0);
        chk("R12 busy", {31'b0, busy}, 32'h0);
        repeat (5) @(negedge clk);
        chk("R12 hold", part_base, b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule